// File: doc/BRIEF.md
# Prescaled 16-bit Interval Timer

The block is a down-counting interval timer that a processor programs through a small synchronous register bus. A prescaler divides the chosen time source, and each prescaled tick decrements a 16-bit counter. When the counter runs out, it reloads the value software last wrote and keeps going, so timeouts repeat at a fixed period. Each timeout sets a sticky status flag. Two independent enable bits route that flag to an interrupt line and to a wake-up line.

The block has two time sources, both given as single-cycle enable strobes in the one system clock domain. One strobe comes from the fast bus clock and the other from a slow 32.768 kHz reference. A select bit in the control word picks one of them. Software stops the timer before it loads a new count and starts it again afterwards. Software can read the counter at any time while the timer runs.

Top module: `pscl_interval_timer`

Register map:
- Address 0 is the control word. Bit 0 is run. Bit 1 selects the slow source. Bit 2 is the interrupt enable. Bit 3 is the wake enable. Bit 4 is the status flag: it reads the flag, and writing 1 to it clears the flag.
- Address 1 holds the prescaler value PRE.
- Address 2 holds the counter. A write loads both the counter and its reload value. A read returns the live count.
- Address 3 reads as zero.

## Requirements
- R1: After reset, the control word, the prescaler and the counter read 0, and irq and wake are low.
- R2: While run (control bit 0) is set, one tick occurs every PRE+1 strobes of the selected source. A counter loaded with N therefore raises the status flag on strobe number (N+1)*(PRE+1).
- R3: When control bit 1 is 1, only slow_stb advances the timer. When control bit 1 is 0, only fast_stb advances it. The strobe of the unselected source has no effect.
- R4: The status flag (control bit 4) stays set until software writes the control word with bit 4 at 1. A write with bit 4 at 0 leaves the flag set.
- R5: irq is high exactly when the status flag and the interrupt enable (control bit 2) are both set. wake is high exactly when the status flag and the wake enable (control bit 3) are both set.
- R6: While run is clear, strobes change neither the counter nor the prescaler phase.
- R7: A read of address 2 returns the live counter value. With PRE=1 and a load of 10, the read returns 7 after 7 strobes.
- R8: On the tick that follows a count of 0, the counter reloads the value last written to address 2 and keeps running. The next timeout then comes another (N+1)*(PRE+1) strobes later.
- R9: A write to address 2 restarts the prescaler phase, and it takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_stb | input | 1 | Fast-source enable strobe |
| slow_stb | input | 1 | Slow-source enable strobe |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write qualifier |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| irq | output | 1 | Timeout interrupt |
| wake | output | 1 | Timeout wake-up |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescaler and a 16-bit data bus. Random runs use prescaler values up to 5 and counts up to 12. With those values, a single timeout and the reload that follows it finish within a few hundred cycles, so many periods fit in one run. Each run checks, from the strobe count alone, the strobe on which irq rises. Directed cases cover source selection with the other strobe toggling, a restart of the prescaler phase in mid-count, a hold while stopped, and every combination of the output gates.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_PRE  = 1;
   localparam int unsigned ADDR_CNT  = 2;

   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_SLOW = 1;
   localparam int unsigned CB_IE   = 2;
   localparam int unsigned CB_WE   = 3;
   localparam int unsigned CB_STS  = 4;
   localparam int unsigned CTRL_W  = 5;

   typedef struct packed {
      logic sts;
      logic wake_en;
      logic irq_en;
      logic slow_sel;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/ivt_ctrl_regs.sv
module ivt_ctrl_regs
   import ivt_pkg::*;
#(
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_pre,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output ctrl_t             ctrl,
   output logic [PRE_W-1:0]  pre
);
   logic clr_req;
   assign clr_req = wr_ctrl && wdata[CB_STS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         pre  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en       <= wdata[CB_EN];
            ctrl.slow_sel <= wdata[CB_SLOW];
            ctrl.irq_en   <= wdata[CB_IE];
            ctrl.wake_en  <= wdata[CB_WE];
         end
         if (expire)
            ctrl.sts <= 1'b1;
         else if (clr_req)
            ctrl.sts <= 1'b0;
         if (wr_pre)
            pre <= wdata[PRE_W-1:0];
      end
   end

   // R4: flag is sticky until a write-one clear
   a_r4_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.sts && !clr_req) |=> ctrl.sts);

   // R4: an expiry always leaves the flag set
   a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> ctrl.sts);
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             stb,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   logic [PRE_W-1:0] phase_q;
   logic             wrap;

   assign wrap = (phase_q >= pre);
   assign tick = run && stb && !restart && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart)
         phase_q <= '0;
      else if (stb)
         phase_q <= wrap ? '0 : phase_q + 1'b1;
   end

   // R6: phase holds between strobes while running
   a_r6_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !stb && !restart) |=> $stable(phase_q));

   // R2: a tick returns the phase to zero
   a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (phase_q == '0));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   logic [CNT_W-1:0] reload_q;
   logic             at_zero;

   assign at_zero = (cnt == '0);
   assign expire  = tick && !load && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         reload_q <= '0;
      end else if (load) begin
         cnt      <= load_val;
         reload_q <= load_val;
      end else if (tick) begin
         cnt <= at_zero ? reload_q : cnt - 1'b1;
      end
   end

   // R6: no tick, no load -> count is frozen
   a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));

   // R8: expiry reloads the stored value
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(reload_q)));

   // R2: a tick on a nonzero count steps down by one
   a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && !at_zero) |=> (cnt == $past(cnt) - 1'b1));

   // R9: a load wins over any tick
   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/pscl_interval_timer.sv
module pscl_interval_timer
   import ivt_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_stb,
   input  logic              slow_stb,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              wake
);
   localparam int unsigned N_REGS = 1 << ADDR_W;

   generate
      if (DATA_W < CNT_W || DATA_W < PRE_W || DATA_W < CTRL_W) begin : g_bad_data_w
         $error("DATA_W too narrow for the registers");
      end
      if (N_REGS < 3) begin : g_bad_addr_w
         $error("ADDR_W must decode at least three registers");
      end
      if (PRE_W < 1 || CNT_W < 2) begin : g_bad_widths
         $error("PRE_W and CNT_W too small");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] cnt;
   logic             wr_en, wr_ctrl, wr_pre, wr_cnt;
   logic             src_stb, tick, expire;

   assign wr_en   = bus_sel && bus_wr;
   assign wr_ctrl = wr_en && (bus_addr == ADDR_W'(ADDR_CTRL));
   assign wr_pre  = wr_en && (bus_addr == ADDR_W'(ADDR_PRE));
   assign wr_cnt  = wr_en && (bus_addr == ADDR_W'(ADDR_CNT));
   assign src_stb = ctrl.slow_sel ? slow_stb : fast_stb;

   ivt_ctrl_regs #(.PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_pre  (wr_pre),
      .wdata   (bus_wdata),
      .expire  (expire),
      .ctrl    (ctrl),
      .pre     (pre)
   );

   ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.en),
      .stb     (src_stb),
      .restart (wr_cnt),
      .pre     (pre),
      .tick    (tick)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_cnt),
      .load_val (bus_wdata[CNT_W-1:0]),
      .cnt      (cnt),
      .expire   (expire)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_CTRL))
         bus_rdata = DATA_W'(ctrl);
      else if (bus_addr == ADDR_W'(ADDR_PRE))
         bus_rdata = DATA_W'(pre);
      else if (bus_addr == ADDR_W'(ADDR_CNT))
         bus_rdata = DATA_W'(cnt);
   end

   assign irq  = ctrl.sts && ctrl.irq_en;
   assign wake = ctrl.sts && ctrl.wake_en;

   // R1: outputs quiet in the first cycle out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!irq && !wake));

   // R3: with the run bit set and no writes, a tick needs a strobe of the selected source
   a_r3_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.slow_sel && !slow_stb && !wr_en) |=> $stable(cnt));
endmodule

// File: tb/pscl_interval_timer_bench.sv
`timescale 1ns/1ps
module pscl_interval_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast_stb = 1'b0, slow_stb = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, wake;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pscl_interval_timer u_pscl_interval_timer (
      .clk(clk), .rst_n(rst_n), .fast_stb(fast_stb), .slow_stb(slow_stb),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake));

   localparam logic [15:0] C_EN = 16'h1, C_SLOW = 16'h2, C_IE = 16'h4,
                           C_WE = 16'h8, C_STS = 16'h10;

   function automatic int exp_strobes(input int n, input int p);
      return (n + 1) * (p + 1);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      fast_stb = 1'b0; slow_stb = 1'b0;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      @(negedge clk);
      fast_stb = 1'b0; slow_stb = 1'b0;
      bus_addr = a;
      #1 d = int'(bus_rdata);
   endtask

   // counts selected-source strobes until irq rises; returns that count or -1
   task automatic measure(input bit use_slow, input bit fast_all, output int first);
      int sc = 0;
      first = -1;
      for (int cyc = 0; cyc < 6000; cyc++) begin
         @(negedge clk);
         fast_stb = fast_all ? 1'b1 : 1'($urandom % 2);
         slow_stb = (cyc % 3 == 0);
         @(posedge clk);
         if (use_slow ? slow_stb : fast_stb) sc++;
         #1;
         if (irq) begin first = sc; break; end
      end
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); fast_stb = 1'b1; slow_stb = 1'b1;
      end
   endtask

   initial begin
      #(5.0 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v, f, seed;
      seed = $urandom(32'd4242);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 pre", v, 0);
      rd(2'd2, v); chk("R1 cnt", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 wake", int'(wake), 0);

      // R2 / R8 directed: fast source, PRE=2, N=4
      wr(2'd1, 16'd2); wr(2'd2, 16'd4); wr(2'd0, C_EN | C_IE);
      measure(1'b0, 1'b1, f); chk("R2 first timeout", f, exp_strobes(4, 2));
      wr(2'd0, C_EN | C_IE | C_STS);
      measure(1'b0, 1'b1, f); chk("R8 second timeout", f, exp_strobes(4, 2));

      // R4 sticky, R5 gates
      rd(2'd0, v); chk("R4 flag set", (v >> 4) & 1, 1);
      wr(2'd0, C_EN | C_IE);
      rd(2'd0, v); chk("R4 write zero keeps flag", (v >> 4) & 1, 1);
      wr(2'd0, C_EN | C_WE);
      #1; chk("R5 irq gated off", int'(irq), 0); chk("R5 wake on", int'(wake), 1);
      wr(2'd0, C_EN);
      #1; chk("R5 both off", int'(irq) + int'(wake), 0);
      wr(2'd0, C_EN | C_IE | C_WE);
      #1; chk("R5 both on", int'(irq) + int'(wake), 2);
      wr(2'd0, C_EN | C_IE | C_WE | C_STS);
      rd(2'd0, v); chk("R4 cleared", (v >> 4) & 1, 0);
      chk("R5 cleared irq", int'(irq), 0);

      // R7 live read, R6 hold while stopped
      wr(2'd0, C_STS); wr(2'd1, 16'd1); wr(2'd2, 16'd10); wr(2'd0, C_EN | C_IE);
      strobes(7);
      rd(2'd2, v); chk("R7 live count", v, 7);
      wr(2'd0, C_IE);
      strobes(9);
      rd(2'd2, v); chk("R6 stopped hold", v, 7);

      // R3 slow source with fast toggling
      wr(2'd1, 16'd1); wr(2'd2, 16'd3); wr(2'd0, C_EN | C_IE | C_SLOW);
      measure(1'b1, 1'b0, f); chk("R3 slow source", f, exp_strobes(3, 1));

      // R9 mid-count reload restarts prescaler phase
      wr(2'd0, C_STS); wr(2'd1, 16'd3); wr(2'd2, 16'd5); wr(2'd0, C_EN | C_IE);
      strobes(2);
      wr(2'd2, 16'd5);
      measure(1'b0, 1'b1, f); chk("R9 phase restart", f, exp_strobes(5, 3));

      // random runs
      for (int k = 0; k < 30; k++) begin
         int p, n;
         bit sl;
         p  = $urandom % 6;
         n  = $urandom % 13;
         sl = 1'($urandom % 2);
         wr(2'd0, C_STS);
         wr(2'd1, 16'(p));
         wr(2'd2, 16'(n));
         wr(2'd0, C_EN | C_IE | (sl ? C_SLOW : 16'h0));
         measure(sl, 1'b0, f);
         chk(sl ? "R3 random slow timeout" : "R2 random fast timeout", f, exp_strobes(n, p));
         wr(2'd0, C_EN | C_IE | C_STS | (sl ? C_SLOW : 16'h0));
         measure(sl, 1'b0, f);
         chk("R8 random repeat", f, exp_strobes(n, p));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule